// File: doc/BRIEF.md
# Countdown Watchdog with Selectable Time Base and Reset Pulse Shaping

This block is a watchdog timer that sits behind a byte-wide indexed register port. Software loads an 8-bit count into the time register. Every load restarts the countdown, so a periodic rewrite keeps the system alive. The count falls by one on every second or every minute, whichever time base is selected. Ticks come from a prescaler of the system clock whose ratios are parameters.

When the count runs out, the block sets a sticky timeout flag so that software can later see that the watchdog caused the reset. It also pulls an active-low reset line. The line either stays low as a steady level, or falls for a fixed-width pulse chosen by a two-bit code.

The countdown runs only while two enables are both set: a bit in the configuration register and an external device-enable input. A separate output-enable bit decides whether the reset line is driven at all.

Top module: `sio_wdog`

## Requirements
- R1: After reset the reset output is high, and registers 0xF0, 0xF5 and 0xF6 all read 0.
- R2: Register 0xF0 keeps only bit 7 (output enable). Register 0xF5 keeps bit 5 (enable), bit 4 (1 = pulse, 0 = level), bit 3 (1 = minutes, 0 = seconds) and bits 1:0 (pulse width code). Bit 6 of 0xF5 reads back the timeout status. The other bits of these registers read 0, and any other address reads 0.
- R3: In seconds mode, writing N (N > 0) to 0xF6 makes the output fall exactly N·MS_PER_SEC·CLKS_PER_MS clocks after the write edge. While counting, a read of 0xF6 returns the remaining count.
- R4: In minutes mode (0xF5 bit 3 = 1), one count lasts SEC_PER_MIN seconds, so expiry comes N·SEC_PER_MIN·MS_PER_SEC·CLKS_PER_MS clocks after the write.
- R5: The count advances only while 0xF5 bit 5 and the ldev_en input are both 1. Otherwise the count holds and the prescaler is held at zero.
- R6: In level mode the output stays low after expiry until 0xF6 is written, or until the count is stopped by a cleared enable.
- R7: In pulse mode the output is low for exactly W·CLKS_PER_MS clocks and then rises. W is set by the width code: 0 = 1 ms, 1 = 25 ms, 2 = 125 ms, 3 = 5000 ms.
- R8: With 0xF0 bit 7 = 0 the output stays high on expiry, but the timeout status is still set.
- R9: The timeout status (0xF5 bit 6) is set on expiry and stays set across writes to 0xF6. It is cleared only by writing 0xF5 with bit 6 = 1.
- R10: A count of 0 never expires. The output stays high and the status is not set.
- R11: Rewriting 0xF6 before expiry restarts the full period from the rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register index |
| wdata | input | 8 | Write data |
| ldev_en | input | 1 | Device enable; the count runs only while this is 1 |
| rdata | output | 8 | Read data, combinational from addr while rd_en is 1, else 0 |
| wdt_rst_n | output | 1 | Active-low watchdog reset output |

## Verification
A write to 0xF6 takes effect at the clock edge that samples it. The output falls right after edge number N·(prescale) counted from that edge, and the bench counts rising edges from the write and samples the output on each falling edge. The low time of a pulse is counted the same way: the first falling edge where the output is low counts as cycle one. Reads are combinational, so the bench sets up a read on a falling edge and samples one nanosecond later. Effects of enable and status writes are checked on the falling edge right after the write edge.

// File: rtl/sio_wdog_pkg.sv
package sio_wdog_pkg;

    localparam logic [7:0] ADDR_OUTCFG = 8'hF0;
    localparam logic [7:0] ADDR_CFG    = 8'hF5;
    localparam logic [7:0] ADDR_TIME   = 8'hF6;

    localparam int OUT_EN_BIT = 7;
    localparam int STS_BIT    = 6;
    localparam int EN_BIT     = 5;
    localparam int PULSE_BIT  = 4;
    localparam int UNIT_BIT   = 3;

    typedef struct packed {
        logic [7:0] cnt;
        logic       en;
        logic       pulse_mode;
        logic       unit_min;
        logic [1:0] width;
        logic       sts;
        logic       out_en;
        logic       lvl;
    } wdog_state_t;

    // pulse width in milliseconds for a two-bit code
    function automatic int unsigned width_ms(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 25;
            2'd2:    return 125;
            default: return 5000;
        endcase
    endfunction

endpackage

// File: rtl/sio_wdog_tick.sv
module sio_wdog_tick #(
    parameter int CLKS_PER_MS = 1000,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_PER_MIN = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    input  logic minutes,
    output logic unit_tick
);
    localparam int CW = (CLKS_PER_MS > 1) ? $clog2(CLKS_PER_MS) : 1;
    localparam int MW = (MS_PER_SEC  > 1) ? $clog2(MS_PER_SEC)  : 1;
    localparam int SW = (SEC_PER_MIN > 1) ? $clog2(SEC_PER_MIN) : 1;

    typedef struct packed {
        logic [CW-1:0] clk_cnt;
        logic [MW-1:0] ms_cnt;
        logic [SW-1:0] sec_cnt;
    } tick_state_t;

    tick_state_t t_q, t_d;
    logic ms_edge, sec_edge;

    always_comb begin
        ms_edge   = (t_q.clk_cnt == CW'(CLKS_PER_MS - 1));
        sec_edge  = ms_edge && (t_q.ms_cnt == MW'(MS_PER_SEC - 1));
        t_d       = t_q;
        if (!run || restart) begin
            t_d = '0;
        end else begin
            t_d.clk_cnt = ms_edge ? '0 : t_q.clk_cnt + 1'b1;
            if (ms_edge)
                t_d.ms_cnt = (t_q.ms_cnt == MW'(MS_PER_SEC - 1)) ? '0 : t_q.ms_cnt + 1'b1;
            if (sec_edge)
                t_d.sec_cnt = (t_q.sec_cnt == SW'(SEC_PER_MIN - 1)) ? '0 : t_q.sec_cnt + 1'b1;
        end
        unit_tick = run && !restart &&
                    (minutes ? (sec_edge && t_q.sec_cnt == SW'(SEC_PER_MIN - 1)) : sec_edge);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    a_r5_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        unit_tick |-> run);

    a_r5_held_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (t_q == '0));

endmodule

// File: rtl/sio_wdog_pulse.sv
module sio_wdog_pulse
    import sio_wdog_pkg::*;
#(
    parameter int CLKS_PER_MS = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       abort,
    input  logic [1:0] code,
    output logic       busy
);
    localparam int MAXC = 5000 * CLKS_PER_MS;
    localparam int PW   = $clog2(MAXC + 1);

    logic [PW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (abort)
            cnt_d = '0;
        else if (start)
            cnt_d = PW'(width_ms(code) * CLKS_PER_MS);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
        busy = (cnt_q != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    a_r7_pulse_step: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !start && !abort) |=> (cnt_q == $past(cnt_q) - 1'b1));

    a_r7_pulse_load: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !abort) |=> busy);

endmodule

// File: rtl/sio_wdog.sv
module sio_wdog
    import sio_wdog_pkg::*;
#(
    parameter int CLKS_PER_MS = 1000,
    parameter int MS_PER_SEC  = 1000,
    parameter int SEC_PER_MIN = 60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    input  logic       ldev_en,
    output logic [7:0] rdata,
    output logic       wdt_rst_n
);
    wdog_state_t s_q, s_d;
    logic time_wr, cfg_wr, out_wr, running, unit_tick, expire, pulse_busy;

    sio_wdog_tick #(
        .CLKS_PER_MS(CLKS_PER_MS),
        .MS_PER_SEC (MS_PER_SEC),
        .SEC_PER_MIN(SEC_PER_MIN)
    ) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .restart  (time_wr),
        .minutes  (s_q.unit_min),
        .unit_tick(unit_tick)
    );

    sio_wdog_pulse #(
        .CLKS_PER_MS(CLKS_PER_MS)
    ) u_pulse (
        .clk  (clk),
        .rst_n(rst_n),
        .start(expire && s_q.pulse_mode),
        .abort(!running),
        .code (s_q.width),
        .busy (pulse_busy)
    );

    always_comb begin
        time_wr = wr_en && (addr == ADDR_TIME);
        cfg_wr  = wr_en && (addr == ADDR_CFG);
        out_wr  = wr_en && (addr == ADDR_OUTCFG);
        running = s_q.en && ldev_en;
        expire  = running && unit_tick && (s_q.cnt == 8'd1) && !time_wr;

        s_d = s_q;
        if (out_wr)
            s_d.out_en = wdata[OUT_EN_BIT];
        if (cfg_wr) begin
            s_d.en         = wdata[EN_BIT];
            s_d.pulse_mode = wdata[PULSE_BIT];
            s_d.unit_min   = wdata[UNIT_BIT];
            s_d.width      = wdata[1:0];
            if (wdata[STS_BIT])
                s_d.sts = 1'b0;
        end
        if (time_wr) begin
            s_d.cnt = wdata;
            s_d.lvl = 1'b0;
        end else if (running && unit_tick && s_q.cnt != 8'd0) begin
            s_d.cnt = s_q.cnt - 8'd1;
        end
        if (!running)
            s_d.lvl = 1'b0;
        if (expire) begin
            s_d.sts = 1'b1;
            if (!s_q.pulse_mode)
                s_d.lvl = 1'b1;
        end

        rdata = 8'h00;
        if (rd_en) begin
            case (addr)
                ADDR_OUTCFG: rdata = {s_q.out_en, 7'b0};
                ADDR_CFG:    rdata = {1'b0, s_q.sts, s_q.en, s_q.pulse_mode,
                                      s_q.unit_min, 1'b0, s_q.width};
                ADDR_TIME:   rdata = s_q.cnt;
                default:     rdata = 8'h00;
            endcase
        end

        wdt_rst_n = !(s_q.out_en && running && (s_q.lvl || pulse_busy));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    a_r8_output_gated: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.out_en |-> wdt_rst_n);

    a_r9_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.sts && !(cfg_wr && wdata[STS_BIT])) |=> s_q.sts);

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !time_wr |=> (s_q.cnt == $past(s_q.cnt) || s_q.cnt == $past(s_q.cnt) - 8'd1));

    a_r10_zero_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cnt == 8'd0 && !time_wr) |=> (s_q.cnt == 8'd0 && !$rose(s_q.sts)));

    a_r5_halted_count: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !time_wr) |=> $stable(s_q.cnt));

    a_r6_idle_releases: assert property (@(posedge clk) disable iff (!rst_n)
        !running |-> wdt_rst_n);

endmodule

// File: tb/tb_sio_wdog.sv
module tb_sio_wdog;
    localparam int CPM = 2;
    localparam int MPS = 8;
    localparam int SPM = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0, ldev_en = 1'b0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic [7:0] rdata;
    logic wdt_rst_n;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    sio_wdog #(.CLKS_PER_MS(CPM), .MS_PER_SEC(MPS), .SEC_PER_MIN(SPM)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .ldev_en(ldev_en),
        .rdata(rdata), .wdt_rst_n(wdt_rst_n)
    );

    function automatic int exp_expire(input int n, input bit minutes);
        return n * (minutes ? SPM : 1) * MPS * CPM;
    endfunction

    function automatic int exp_pulse(input int code);
        case (code)
            0: return 1 * CPM;
            1: return 25 * CPM;
            2: return 125 * CPM;
            default: return 5000 * CPM;
        endcase
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        rd_en = 1'b1; addr = a;
        #1;
        v = int'(rdata);
        rd_en = 1'b0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic time_to_low(input int maxc, output int n);
        n = 0;
        while (n < maxc) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (!wdt_rst_n) break;
        end
    endtask

    task automatic low_len(output int m);
        m = 1;
        while (m < 20000) begin
            @(posedge clk);
            @(negedge clk);
            if (wdt_rst_n) break;
            m++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v, n, m;
        int unsigned seed_init;
        seed_init = $urandom(32'd2024);
        repeat (5) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 output", int'(wdt_rst_n), 1);
        rd(8'hF0, v); chk("R1 reg F0", v, 0);
        rd(8'hF5, v); chk("R1 reg F5", v, 0);
        rd(8'hF6, v); chk("R1 reg F6", v, 0);

        // R2 register fields
        wr(8'hF0, 8'hFF); rd(8'hF0, v); chk("R2 F0 readback", v, 8'h80);
        wr(8'hF5, 8'hFF); rd(8'hF5, v); chk("R2 F5 readback", v, 8'h3B);
        rd(8'h12, v); chk("R2 unknown addr", v, 0);
        wr(8'hF5, 8'h00);
        ldev_en = 1'b1;

        // R3 seconds countdown with readback
        wr(8'hF5, 8'h20);
        wr(8'hF6, 8'd5);
        wait_cyc(16);
        rd(8'hF6, v); chk("R3 remaining count", v, 4);
        time_to_low(2000, n); chk("R3 expiry time", n, exp_expire(5, 0) - 16);

        // R6 level holds, R9 status
        wait_cyc(20);
        chk("R6 level held", int'(wdt_rst_n), 0);
        rd(8'hF5, v); chk("R9 status set", v, 8'h60);
        wr(8'hF6, 8'd0);
        chk("R6 release on time write", int'(wdt_rst_n), 1);
        // R10 zero count never expires
        wait_cyc(100);
        chk("R10 output high", int'(wdt_rst_n), 1);
        rd(8'hF5, v); chk("R9 status kept over time write", v, 8'h60);
        wr(8'hF5, 8'h60);
        rd(8'hF5, v); chk("R9 status cleared", v, 8'h20);
        wait_cyc(50);
        rd(8'hF5, v); chk("R10 no status from zero count", v, 8'h20);

        // R6 release on enable clear
        wr(8'hF6, 8'd1);
        time_to_low(2000, n); chk("R3 one count", n, exp_expire(1, 0));
        wr(8'hF5, 8'h00);
        chk("R6 release on enable clear", int'(wdt_rst_n), 1);
        wr(8'hF5, 8'h60);

        // R11 keepalive restarts
        wr(8'hF6, 8'd3);
        wait_cyc(30);
        chk("R11 not yet expired", int'(wdt_rst_n), 1);
        wr(8'hF6, 8'd3);
        time_to_low(2000, n); chk("R11 full period after rewrite", n, exp_expire(3, 0));
        wr(8'hF6, 8'd0);

        // R5 device enable gating
        @(negedge clk); ldev_en = 1'b0;
        wr(8'hF6, 8'd2);
        wait_cyc(100);
        chk("R5 no expiry with ldev off", int'(wdt_rst_n), 1);
        rd(8'hF6, v); chk("R5 count held", v, 2);
        ldev_en = 1'b1;
        time_to_low(2000, n); chk("R5 counts after ldev on", n, exp_expire(2, 0));
        wr(8'hF6, 8'd0);
        wr(8'hF5, 8'h40);
        wr(8'hF6, 8'd2);
        wait_cyc(100);
        rd(8'hF6, v); chk("R5 count held with enable bit off", v, 2);
        wr(8'hF5, 8'h20);
        time_to_low(2000, n); chk("R5 counts after enable bit set", n, exp_expire(2, 0));
        wr(8'hF6, 8'd0);

        // R8 output enable off
        wr(8'hF0, 8'h00);
        wr(8'hF5, 8'h60);
        wr(8'hF6, 8'd1);
        time_to_low(40, n); chk("R8 output never low", n, 40);
        chk("R8 output high", int'(wdt_rst_n), 1);
        rd(8'hF5, v); chk("R8 status still set", v & 8'h40, 8'h40);
        wr(8'hF0, 8'h80);
        wr(8'hF6, 8'd0);

        // R4 minutes
        wr(8'hF5, 8'h68);
        wr(8'hF6, 8'd1);
        time_to_low(5000, n); chk("R4 one minute", n, exp_expire(1, 1));
        wr(8'hF6, 8'd2);
        time_to_low(5000, n); chk("R4 two minutes", n, exp_expire(2, 1));
        wr(8'hF6, 8'd0);

        // R7 every pulse width code
        for (int code = 0; code < 4; code++) begin
            wr(8'hF5, 8'h70 | 8'(code));
            wr(8'hF6, 8'd1);
            time_to_low(2000, n); chk("R7 pulse expiry time", n, exp_expire(1, 0));
            low_len(m); chk("R7 pulse width", m, exp_pulse(code));
        end

        // random mix, pulse and level
        for (int it = 0; it < 8; it++) begin
            int nn, code;
            bit lvl;
            nn = 1 + int'($urandom % 4);
            code = int'($urandom % 3);
            lvl = bit'($urandom % 2);
            wr(8'hF5, (lvl ? 8'h60 : 8'h70) | 8'(code));
            wr(8'hF6, 8'(nn));
            time_to_low(2000, n); chk("R3 random expiry", n, exp_expire(nn, 0));
            if (lvl) begin
                wait_cyc(exp_pulse(code) + 3);
                chk("R6 random level held", int'(wdt_rst_n), 0);
                wr(8'hF6, 8'd0);
                chk("R6 random release", int'(wdt_rst_n), 1);
            end else begin
                low_len(m); chk("R7 random pulse width", m, exp_pulse(code));
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule